// File: doc/BRIEF.md
# DRAM Bank Strobe and Row-Address Controller

This block steers a shared DRAM array that both a 16-bit CPU and a video fetch engine use. On every access it multiplexes a row address and then a column address onto one address bus. It also drives one active-low column strobe per half-bank. Eight banks are decoded from three upper address lines, and each bank has a low-word strobe and a high-word strobe, so there are sixteen strobes in all.

Video fetches take their low eight row bits from an internal sequential counter. That counter doubles as the refresh source. Row bits above the counter come from CPU address lines. Bit 18 supplies row bit 8, and the bank lines supply any bit above that. Each bank-select line has a companion "driven" qualifier. When a line is not driven, it reads as logic 1, so the bank decode never depends on a floating input.

A coverage monitor records every row that is strobed during a fixed window of clock cycles. At the end of each window it reports whether any row was missed.

The control path is a state machine in the `clk` domain. `ras_n` and `phase_clk` are sampled on `clk`. The machine has five states:

- **IDLE**: the live row address is on the bus.
- **ROW_HOLD**: the latched row is held for one cycle.
- **COL_SETUP**: the bus carries the column and all strobes are off.
- **COL_ACT**: the selected strobes are asserted.
- **SKIP**: a row-strobe fall was rejected.

The named transitions are:

- *fall_ok*: IDLE→ROW_HOLD, when `ras_n` falls with `phase_clk` high.
- *fall_skip*: IDLE→SKIP, when `ras_n` falls with `phase_clk` low.
- *advance*: ROW_HOLD→COL_SETUP→COL_ACT.
- *ras_rise*: from ROW_HOLD, COL_SETUP, COL_ACT or SKIP back to IDLE, when `ras_n` is sampled high.

Top module: `dram_strobe_ctl`

## Requirements
- R1: While reset is applied, all sixteen `cas_n` are 1, `refresh_miss` is 0 and `refresh_window_end` is 0.
- R2: In IDLE on a CPU access, `dram_addr[7:0]` equals `cpu_addr[8:1]` and `dram_addr[8]` equals `cpu_addr[18]`.
- R3: A fall of `ras_n` (1 at the previous edge, 0 at this one) is accepted only while `phase_clk` is 1. A fall with `phase_clk` at 0 asserts no strobe and leaves the video counter unchanged until `ras_n` returns high.
- R4: After an accepted fall at edge E, `dram_addr` keeps the row through E+1. It then carries the column from E+1 onward, with all strobes still off until E+2. The column is `cpu_addr[17:9]` on a CPU access and `video_col` on a video access.
- R5: A CPU access asserts exactly one strobe, at index 2*bank + `cpu_addr[18]`. Here bank is the 3-bit effective bank value, with bit k taken from `bank_sel[k]`.
- R6: Each effective bank bit equals `bank_sel[k]` when `bank_drv[k]` is 1, and equals 1 when `bank_drv[k]` is 0.
- R7: A video access (`video_sel` 1 at the accepted fall) asserts strobes 2*VID_BANK and 2*VID_BANK+1 (0 and 1 by default) and no others.
- R8: All strobes are 1 after the first edge at which `ras_n` is sampled 1.
- R9: On a video access the low eight row bits come from a counter. The counter is 0 after reset, advances by one per accepted video access, and wraps from 255 to 0. Row bit 8 still comes from `cpu_addr[18]`.
- R10: Every WIN_CYC cycles `refresh_window_end` pulses for one cycle. At that pulse, `refresh_miss` becomes 1 if any of the 2^ROW_BITS row values went unlatched during that window, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all strobe inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_clk | input | 1 | Phase clock; a row latch is valid only while it is high |
| ras_n | input | 1 | Active-low row strobe seen by the DRAM |
| video_sel | input | 1 | 1 = video fetch cycle, 0 = CPU cycle |
| cpu_addr | input | 18 (bits 18:1) | CPU word address within a bank |
| bank_sel | input | 3 | Bank-select address lines |
| bank_drv | input | 3 | Per-line qualifier; 0 means the line is undriven |
| video_col | input | 9 | Column address of a video fetch |
| dram_addr | output | 9 | Multiplexed row/column address |
| cas_n | output | 16 | Active-low column strobes, two per bank |
| refresh_miss | output | 1 | Result of the last coverage window |
| refresh_window_end | output | 1 | One-cycle pulse at each window end |

## Verification
The live row address appears combinationally in IDLE, so the bench reads it one time step after it drives the inputs. The bench drives `ras_n` low at a falling clock edge; that is E-minus-half. It then expects the latched row half a cycle after E, the column with strobes off after E+1, the strobe pattern after E+2, and released strobes after the first edge that samples `ras_n` high. Every read falls on a falling edge for these reasons. The refresh result is read in the cycle where `refresh_window_end` is seen high, since the miss flag is updated at that same edge. The bench's row model keeps its own counter, advanced only by accepted video accesses, so a counter that moves on a rejected fall shows up as a row mismatch.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_HOLD,
        ST_COL_SETUP,
        ST_COL_ACT,
        ST_SKIP
    } ctl_state_t;
endpackage

// File: rtl/bank_select.sv
module bank_select #(
    parameter int BANK_BITS = 3
) (
    input  logic [BANK_BITS-1:0] sel,
    input  logic [BANK_BITS-1:0] drv,
    output logic [BANK_BITS-1:0] eff
);
    // an undriven line falls back to logic 1
    for (genvar g = 0; g < BANK_BITS; g++) begin : g_line
        assign eff[g] = drv[g] ? sel[g] : 1'b1;
    end
endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 9,
    parameter int CNT_BITS = 8,
    parameter int NSTROBE  = 16,
    parameter int MUX_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phase_clk,
    input  logic                ras_n,
    input  logic                video_sel,
    input  logic [ROW_BITS-1:0] row_in,
    input  logic [COL_BITS-1:0] col_in,
    input  logic [NSTROBE-1:0]  mask_in,
    output logic [CNT_BITS-1:0] vcount,
    output logic [NSTROBE-1:0]  cas_n,
    output logic [MUX_W-1:0]    dram_addr,
    output logic                row_event,
    output logic [ROW_BITS-1:0] row_val,
    output logic                col_sel,
    output logic                cyc_video
);
    ctl_state_t state, state_nx;
    logic ras_q;
    logic [COL_BITS-1:0] col_lat;
    logic [NSTROBE-1:0]  mask_lat;
    logic fall, take;

    assign fall = ras_q & ~ras_n;
    assign take = (state == ST_IDLE) && fall && phase_clk;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fall && phase_clk)  state_nx = ST_ROW_HOLD;
                else if (fall)          state_nx = ST_SKIP;
            end
            ST_ROW_HOLD:  state_nx = ras_n ? ST_IDLE : ST_COL_SETUP;
            ST_COL_SETUP: state_nx = ras_n ? ST_IDLE : ST_COL_ACT;
            ST_COL_ACT:   state_nx = ras_n ? ST_IDLE : ST_COL_ACT;
            ST_SKIP:      state_nx = ras_n ? ST_IDLE : ST_SKIP;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ras_q     <= 1'b1;
            row_val   <= '0;
            col_lat   <= '0;
            mask_lat  <= '0;
            cyc_video <= 1'b0;
            vcount    <= '0;
            row_event <= 1'b0;
        end else begin
            state     <= state_nx;
            ras_q     <= ras_n;
            row_event <= take;
            if (take) begin
                row_val   <= row_in;
                col_lat   <= col_in;
                mask_lat  <= mask_in;
                cyc_video <= video_sel;
                if (video_sel) vcount <= vcount + CNT_BITS'(1);
            end
        end
    end

    always_comb begin
        dram_addr = MUX_W'(row_in);
        cas_n     = '1;
        col_sel   = 1'b0;
        unique case (state)
            ST_IDLE, ST_SKIP: dram_addr = MUX_W'(row_in);
            ST_ROW_HOLD:      dram_addr = MUX_W'(row_val);
            ST_COL_SETUP: begin
                dram_addr = MUX_W'(col_lat);
                col_sel   = 1'b1;
            end
            ST_COL_ACT: begin
                dram_addr = MUX_W'(col_lat);
                col_sel   = 1'b1;
                cas_n     = ~mask_lat;
            end
            default: dram_addr = MUX_W'(row_in);
        endcase
    end
endmodule

// File: rtl/refresh_monitor.sv
module refresh_monitor #(
    parameter int ROW_BITS = 9,
    parameter int WIN_CYC  = 4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_event,
    input  logic [ROW_BITS-1:0] row_val,
    output logic                miss,
    output logic                win_end
);
    localparam int NROWS = 1 << ROW_BITS;
    localparam int WCW   = $clog2(WIN_CYC);

    logic [NROWS-1:0] seen, seen_nx;
    logic [WCW-1:0]   win_cnt;

    always_comb begin
        seen_nx = seen;
        if (row_event) seen_nx[row_val] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= '0;
            win_cnt <= '0;
            miss    <= 1'b0;
            win_end <= 1'b0;
        end else if (win_cnt == WCW'(WIN_CYC - 1)) begin
            win_cnt <= '0;
            miss    <= ~&seen_nx;
            seen    <= '0;
            win_end <= 1'b1;
        end else begin
            win_cnt <= win_cnt + WCW'(1);
            seen    <= seen_nx;
            win_end <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
    parameter int ROW_BITS  = 9,
    parameter int BANK_BITS = 3,
    parameter int VID_BANK  = 0,
    parameter int WIN_CYC   = 4000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          phase_clk,
    input  logic                          ras_n,
    input  logic                          video_sel,
    input  logic [18:1]                   cpu_addr,
    input  logic [BANK_BITS-1:0]          bank_sel,
    input  logic [BANK_BITS-1:0]          bank_drv,
    input  logic [8:0]                    video_col,
    output logic [((ROW_BITS > 9) ? ROW_BITS : 9)-1:0] dram_addr,
    output logic [(2 << BANK_BITS)-1:0]   cas_n,
    output logic                          refresh_miss,
    output logic                          refresh_window_end
);
    localparam int CNT_BITS = 8;
    localparam int COL_BITS = 9;
    localparam int NSTROBE  = 2 << BANK_BITS;
    localparam int MUX_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
    localparam int HI_BITS  = ROW_BITS - CNT_BITS;

    logic [BANK_BITS-1:0] bank_eff;
    logic [ROW_BITS-1:0]  row_cpu, row_vid, row_in;
    logic [COL_BITS-1:0]  col_in;
    logic [NSTROBE-1:0]   cpu_mask, vid_mask, mask_in;
    logic [CNT_BITS-1:0]  vcount;
    logic                 row_event, col_sel, cyc_video;
    logic [ROW_BITS-1:0]  row_val;

    bank_select #(.BANK_BITS(BANK_BITS)) u_bank (
        .sel(bank_sel), .drv(bank_drv), .eff(bank_eff)
    );

    assign row_cpu[CNT_BITS-1:0] = cpu_addr[CNT_BITS:1];
    assign row_vid[CNT_BITS-1:0] = vcount;

    // row bits above the counter come from CPU address lines
    for (genvar k = 0; k < HI_BITS; k++) begin : g_rowhi
        if (k == 0) begin : g_a18
            assign row_cpu[CNT_BITS] = cpu_addr[18];
            assign row_vid[CNT_BITS] = cpu_addr[18];
        end else begin : g_bank
            assign row_cpu[CNT_BITS+k] = bank_eff[k-1];
            assign row_vid[CNT_BITS+k] = bank_eff[k-1];
        end
    end

    assign cpu_mask = NSTROBE'(1) << {bank_eff, cpu_addr[18]};
    assign vid_mask = NSTROBE'(3) << (2 * VID_BANK);

    assign row_in  = video_sel ? row_vid   : row_cpu;
    assign col_in  = video_sel ? video_col : cpu_addr[17:9];
    assign mask_in = video_sel ? vid_mask  : cpu_mask;

    strobe_fsm #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .CNT_BITS(CNT_BITS),
        .NSTROBE(NSTROBE), .MUX_W(MUX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .phase_clk(phase_clk), .ras_n(ras_n),
        .video_sel(video_sel), .row_in(row_in), .col_in(col_in),
        .mask_in(mask_in), .vcount(vcount), .cas_n(cas_n),
        .dram_addr(dram_addr), .row_event(row_event), .row_val(row_val),
        .col_sel(col_sel), .cyc_video(cyc_video)
    );

    refresh_monitor #(.ROW_BITS(ROW_BITS), .WIN_CYC(WIN_CYC)) u_mon (
        .clk(clk), .rst_n(rst_n), .row_event(row_event), .row_val(row_val),
        .miss(refresh_miss), .win_end(refresh_window_end)
    );
endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk #(
    parameter int BANK_BITS = 3,
    parameter int VID_BANK  = 0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ras_n,
    input logic [(2 << BANK_BITS)-1:0] cas_n,
    input logic                        col_sel,
    input logic                        cyc_video,
    input logic                        refresh_window_end
);
    localparam int NSTROBE = 2 << BANK_BITS;
    localparam logic [NSTROBE-1:0] VMASK = NSTROBE'(3) << (2 * VID_BANK);

    // R8
    ras_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |=> (&cas_n));

    // R4
    strobe_after_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cas_n) |-> (col_sel && $past(col_sel)));

    // R7
    video_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_video && !(&cas_n)) |-> ((~cas_n & ~VMASK) == '0));

    // R5
    cpu_single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_video |-> $onehot0(~cas_n));

    // R10
    window_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_window_end |=> !refresh_window_end);
endmodule

bind dram_strobe_ctl dram_strobe_chk #(.BANK_BITS(BANK_BITS), .VID_BANK(VID_BANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .col_sel(col_sel),
    .cyc_video(cyc_video), .refresh_window_end(refresh_window_end)
);

// File: tb/sim_dram_strobe_ctl.sv
`timescale 1ns/1ps
module sim_dram_strobe_ctl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        phase_clk = 1;
    logic        ras_n = 1;
    logic        video_sel = 0;
    logic [18:1] cpu_addr = '0;
    logic [2:0]  bank_sel = '0;
    logic [2:0]  bank_drv = '1;
    logic [8:0]  video_col = '0;
    logic [8:0]  dram_addr;
    logic [15:0] cas_n;
    logic        refresh_miss, refresh_window_end;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] vcount_m = 0;

    dram_strobe_ctl u0 (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] eff_bank(input logic [2:0] s, input logic [2:0] d);
        for (int k = 0; k < 3; k++) eff_bank[k] = d[k] ? s[k] : 1'b1;
    endfunction

    function automatic logic [15:0] exp_mask(input bit vid, input logic [18:1] a,
                                             input logic [2:0] eb);
        if (vid) return 16'h0003;
        return 16'(1) << {eb, a[18]};
    endfunction

    task automatic access(input bit vid, input logic [18:1] a, input logic [2:0] s,
                          input logic [2:0] d, input logic [8:0] c, input bit ph);
        logic [8:0] row, col;
        logic [15:0] m;
        @(negedge clk);
        video_sel = vid; cpu_addr = a; bank_sel = s; bank_drv = d;
        video_col = c; phase_clk = ph;
        row = vid ? {a[18], vcount_m} : {a[18], a[8:1]};
        col = vid ? c : a[17:9];
        m   = exp_mask(vid, a, eff_bank(s, d));
        #1;
        chk(dram_addr == row, vid ? "R9 idle row" : "R2 idle row", dram_addr, row);
        @(negedge clk); ras_n = 0;
        @(negedge clk);
        chk(&cas_n, "R3/R4 no strobe at E", cas_n, 16'hffff);
        if (ph) chk(dram_addr == row, "R4 row held", dram_addr, row);
        @(negedge clk);
        chk(&cas_n, "R4 strobe off in setup", cas_n, 16'hffff);
        if (ph) chk(dram_addr == col, "R4 column", dram_addr, col);
        @(negedge clk);
        if (ph) begin
            chk(~cas_n == m, vid ? "R7 video strobes" : "R5/R6 cpu strobe", ~cas_n, m);
            if (vid) vcount_m = vcount_m + 8'd1;
        end else begin
            chk(&cas_n, "R3 rejected fall", cas_n, 16'hffff);
        end
        ras_n = 1;
        @(negedge clk);
        chk(&cas_n, "R8 release", cas_n, 16'hffff);
        phase_clk = 1;
    endtask

    task automatic wait_window();
        do @(negedge clk); while (!refresh_window_end);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        chk(&cas_n, "R1 strobes", cas_n, 16'hffff);
        chk(refresh_miss == 0, "R1 miss", refresh_miss, 0);
        chk(refresh_window_end == 0, "R1 window", refresh_window_end, 0);
        rst_n = 1;

        // R10: full coverage of 512 rows (counter wraps, R9) inside one window
        for (int i = 0; i < 512; i++)
            access(1, {(i >= 256), 17'($urandom)}, 3'($urandom), 3'b111,
                   9'($urandom), 1);
        wait_window();
        chk(refresh_miss == 0, "R10 full window", refresh_miss, 0);
        // only half of the rows in the next window
        for (int i = 0; i < 256; i++)
            access(1, {1'b0, 17'($urandom)}, 3'($urandom), 3'b111, 9'($urandom), 1);
        wait_window();
        chk(refresh_miss == 1, "R10 partial window", refresh_miss, 1);

        // directed CPU decode and fallback cases
        access(0, 18'h00000, 3'b000, 3'b111, 9'h0, 1);
        access(0, 18'h20000, 3'b111, 3'b111, 9'h0, 1);
        access(0, 18'h3ffff, 3'b000, 3'b000, 9'h0, 1);   // R6 all undriven -> bank 7
        access(0, 18'h1abcd, 3'b000, 3'b101, 9'h0, 1);   // R6 middle line undriven
        access(0, 18'h2aaaa, 3'b011, 3'b110, 9'h0, 1);
        // R3: rejected fall, counter must not move
        access(1, 18'h12345, 3'b010, 3'b111, 9'h1ff, 0);
        access(1, 18'h00001, 3'b010, 3'b111, 9'h155, 1);

        for (int i = 0; i < 300; i++)
            access(1'($urandom), 18'($urandom), 3'($urandom), 3'($urandom),
                   9'($urandom), ($urandom % 8) != 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule